// File: doc/BRIEF.md
# Redundant-Thread Store and Uncached-Load Output Checker

Two copies of one program run side by side, one ahead of the other. Anything either copy tries to send past the edge of the replicated region must first be shown to agree between them. This block does that gatekeeping. A store committed by the leading copy is parked in a queue that belongs to the leading copy alone. A store committed by the trailing copy goes into a second queue of its own. The two queue heads are matched in commit order. A leading store leaves the block only when its trailing partner carries the same address and the same data.

An uncached load has to leave the region too, so its address is checked the same way. The leading copy's address waits in a one-entry slot until the trailing copy presents its own address. Cached loads are not routed through this block, because any wrong value they produce is expected to surface later in a store.

Any disagreement raises a sticky fault and freezes the block. The offending entries stay in place and nothing further is released. A trailing operation that has no leading operation waiting for it raises a separate sticky protocol-error flag. Recovery is left to the surrounding logic.

Top module: `redundant_store_checker`

## Requirements
- R1: After reset, out_st_valid, out_ld_valid, fault_o and proto_err_o are 0, and lead_st_ready and lead_ld_ready are 1.
- R2: A leading store is released on out_st_valid/out_st_addr/out_st_data only after its trailing partner has been committed and both address and data agree. With the leading store already queued, the release is visible in the second cycle after the cycle in which the trailing store is presented.
- R3: Releases keep leading commit order and happen at most once per cycle. The n-th leading store is paired with the n-th accepted trailing store, and leading and trailing stores may be committed in the same cycle.
- R4: A pair that differs in address only, or in data only, is not released, and fault_o rises. fault_o stays 1 until reset.
- R5: While fault_o is 1, no store and no load is released, even for later pairs that agree. The leading store queue keeps accepting stores while it has room.
- R6: The leading store queue holds DEPTH (64) stores. lead_st_ready is 0 exactly when DEPTH leading stores are held. A store offered while lead_st_ready is 0 is not taken.
- R7: A trailing store is accepted only if the count of leading stores accepted in earlier cycles exceeds the count of trailing stores accepted. Otherwise it is dropped, does not consume a pairing slot, and proto_err_o rises and stays 1 until reset.
- R8: A leading uncached load address is held, with lead_ld_ready at 0, until a trailing uncached load arrives. If the two addresses are equal, out_ld_valid/out_ld_addr show that address in the cycle after the trailing load is presented, and lead_ld_ready returns to 1.
- R9: A trailing uncached load whose address differs from the held one is not released. fault_o rises and the held address is kept (lead_ld_ready stays 0).
- R10: A trailing uncached load with no held leading load is not released, and proto_err_o rises.
- R11: If a store pair and a load pair are judged in the same cycle, both are released together when both agree. If either disagrees, neither is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_st_valid | input | 1 | Leading copy commits a store |
| lead_st_addr | input | AW | Leading store address |
| lead_st_data | input | DW | Leading store data |
| lead_st_ready | output | 1 | Leading store queue has room |
| trail_st_valid | input | 1 | Trailing copy commits a store |
| trail_st_addr | input | AW | Trailing store address |
| trail_st_data | input | DW | Trailing store data |
| lead_ld_valid | input | 1 | Leading copy issues an uncached load |
| lead_ld_addr | input | AW | Leading uncached load address |
| lead_ld_ready | output | 1 | Uncached load slot is free |
| trail_ld_valid | input | 1 | Trailing copy issues an uncached load |
| trail_ld_addr | input | AW | Trailing uncached load address |
| out_st_valid | output | 1 | Verified store leaves the region |
| out_st_addr | output | AW | Verified store address |
| out_st_data | output | DW | Verified store data |
| out_ld_valid | output | 1 | Verified uncached load leaves the region |
| out_ld_addr | output | AW | Verified uncached load address |
| fault_o | output | 1 | Sticky disagreement flag |
| proto_err_o | output | 1 | Sticky flag for an unmatched trailing operation |

## Verification
The store comparison and the uncached-load comparison run in parallel and can reach a verdict on the same clock edge. Each affects whether the other may release. The bench lines them up by presenting the trailing load exactly one cycle after the trailing store, which is the cycle in which the stored pair reaches the comparator. It then runs three variants. When both pairs agree, the two releases must carry the same recorded cycle number. When only the store data differs, or only the load address differs, there must be no release on either path, and fault_o must be set.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned RSC_DEPTH_DEFAULT = 64;
  localparam int unsigned RSC_AW_DEFAULT    = 32;
  localparam int unsigned RSC_DW_DEFAULT    = 32;

  // verdict of one comparison lane in the current cycle
  typedef enum logic [1:0] {
    CMP_IDLE   = 2'd0,
    CMP_AGREE  = 2'd1,
    CMP_DIFFER = 2'd2
  } cmp_verdict_e;
endpackage

// File: rtl/rsc_queue.sv
// Per-thread FIFO. Storage has no reset and a registered read port so a
// block RAM can hold it. A bypass covers a write to the next head slot.
module rsc_queue #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned QAW  = $clog2(DEPTH),
  localparam int unsigned CW   = QAW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic          full,
  output logic          head_valid,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]   mem [DEPTH];
  logic [QAW-1:0] wr_ptr, rd_ptr, rd_nxt;
  logic           do_push, do_pop;

  assign full       = (count == CW'(DEPTH));
  assign head_valid = (count != '0);
  assign do_push    = push && !full;
  assign do_pop     = pop && head_valid;
  assign rd_nxt     = do_pop ? rd_ptr + 1'b1 : rd_ptr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (do_push && (wr_ptr == rd_nxt)) head <= din;
    else                               head <= mem[rd_nxt];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_nxt;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rsc_store_cmp.sv
// Compares the two queue heads and registers the verified store.
module rsc_store_cmp
  import rsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lead_valid,
  input  logic [AW-1:0] lead_addr,
  input  logic [DW-1:0] lead_data,
  input  logic         trail_valid,
  input  logic [AW-1:0] trail_addr,
  input  logic [DW-1:0] trail_data,
  input  logic         halt,
  output cmp_verdict_e verdict,
  output logic         pop,
  output logic         rel_valid,
  output logic [AW-1:0] rel_addr,
  output logic [DW-1:0] rel_data
);
  always_comb begin
    if (!(lead_valid && trail_valid))
      verdict = CMP_IDLE;
    else if ((lead_addr == trail_addr) && (lead_data == trail_data))
      verdict = CMP_AGREE;
    else
      verdict = CMP_DIFFER;
  end

  assign pop = (verdict == CMP_AGREE) && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid <= 1'b0;
      rel_addr  <= '0;
      rel_data  <= '0;
    end else begin
      rel_valid <= pop;
      if (pop) begin
        rel_addr <= lead_addr;
        rel_data <= lead_data;
      end
    end
  end
endmodule

// File: rtl/rsc_load_cmp.sv
// One-entry slot for the leading uncached load address; the trailing
// address is compared against it on arrival.
module rsc_load_cmp
  import rsc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lead_valid,
  input  logic [AW-1:0] lead_addr,
  output logic          lead_ready,
  input  logic          trail_valid,
  input  logic [AW-1:0] trail_addr,
  input  logic          halt,
  output cmp_verdict_e  verdict,
  output logic          orphan,
  output logic          rel_valid,
  output logic [AW-1:0] rel_addr
);
  logic          slot_valid;
  logic [AW-1:0] slot_addr;
  logic          release_now;

  assign lead_ready  = !slot_valid;
  assign orphan      = trail_valid && !slot_valid;
  assign release_now = (verdict == CMP_AGREE) && !halt;

  always_comb begin
    if (!(trail_valid && slot_valid))  verdict = CMP_IDLE;
    else if (trail_addr == slot_addr)  verdict = CMP_AGREE;
    else                               verdict = CMP_DIFFER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid <= 1'b0;
      slot_addr  <= '0;
      rel_valid  <= 1'b0;
      rel_addr   <= '0;
    end else begin
      rel_valid <= release_now;
      if (release_now) begin
        rel_addr   <= slot_addr;
        slot_valid <= 1'b0;
      end else if (lead_valid && !slot_valid) begin
        slot_addr  <= lead_addr;
        slot_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/redundant_store_checker.sv
module redundant_store_checker
  import rsc_pkg::*;
#(
  parameter int unsigned AW    = RSC_AW_DEFAULT,
  parameter int unsigned DW    = RSC_DW_DEFAULT,
  parameter int unsigned DEPTH = RSC_DEPTH_DEFAULT,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned EW   = AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lead_st_valid,
  input  logic [AW-1:0] lead_st_addr,
  input  logic [DW-1:0] lead_st_data,
  output logic          lead_st_ready,
  input  logic          trail_st_valid,
  input  logic [AW-1:0] trail_st_addr,
  input  logic [DW-1:0] trail_st_data,
  input  logic          lead_ld_valid,
  input  logic [AW-1:0] lead_ld_addr,
  output logic          lead_ld_ready,
  input  logic          trail_ld_valid,
  input  logic [AW-1:0] trail_ld_addr,
  output logic          out_st_valid,
  output logic [AW-1:0] out_st_addr,
  output logic [DW-1:0] out_st_data,
  output logic          out_ld_valid,
  output logic [AW-1:0] out_ld_addr,
  output logic          fault_o,
  output logic          proto_err_o
);
  logic          lead_full, lead_hv, trail_full, trail_hv;
  logic [EW-1:0] lead_head, trail_head;
  logic [CW-1:0] lead_cnt, trail_cnt;
  logic          lead_push, trail_ok, trail_push, st_orphan, pair_pop;
  logic          ld_orphan, fault_q, proto_q;
  cmp_verdict_e  st_verdict, ld_verdict;

  assign lead_st_ready = !lead_full;
  assign lead_push     = lead_st_valid && !lead_full;
  // trailing store is legal only while an unmatched leading store exists
  assign trail_ok      = (lead_cnt > trail_cnt);
  assign trail_push    = trail_st_valid && trail_ok;
  assign st_orphan     = trail_st_valid && !trail_ok;

  rsc_queue #(.W(EW), .DEPTH(DEPTH)) u_lead_q (
    .clk(clk), .rst(rst),
    .push(lead_push), .din({lead_st_addr, lead_st_data}),
    .pop(pair_pop), .full(lead_full), .head_valid(lead_hv),
    .head(lead_head), .count(lead_cnt)
  );

  rsc_queue #(.W(EW), .DEPTH(DEPTH)) u_trail_q (
    .clk(clk), .rst(rst),
    .push(trail_push), .din({trail_st_addr, trail_st_data}),
    .pop(pair_pop), .full(trail_full), .head_valid(trail_hv),
    .head(trail_head), .count(trail_cnt)
  );

  rsc_store_cmp #(.AW(AW), .DW(DW)) u_st_cmp (
    .clk(clk), .rst(rst),
    .lead_valid(lead_hv),
    .lead_addr(lead_head[EW-1:DW]), .lead_data(lead_head[DW-1:0]),
    .trail_valid(trail_hv && !trail_full),
    .trail_addr(trail_head[EW-1:DW]), .trail_data(trail_head[DW-1:0]),
    .halt(fault_q || (ld_verdict == CMP_DIFFER)),
    .verdict(st_verdict), .pop(pair_pop),
    .rel_valid(out_st_valid), .rel_addr(out_st_addr), .rel_data(out_st_data)
  );

  rsc_load_cmp #(.AW(AW)) u_ld_cmp (
    .clk(clk), .rst(rst),
    .lead_valid(lead_ld_valid), .lead_addr(lead_ld_addr),
    .lead_ready(lead_ld_ready),
    .trail_valid(trail_ld_valid), .trail_addr(trail_ld_addr),
    .halt(fault_q || (st_verdict == CMP_DIFFER)),
    .verdict(ld_verdict), .orphan(ld_orphan),
    .rel_valid(out_ld_valid), .rel_addr(out_ld_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q <= 1'b0;
      proto_q <= 1'b0;
    end else begin
      fault_q <= fault_q || (st_verdict == CMP_DIFFER) || (ld_verdict == CMP_DIFFER);
      proto_q <= proto_q || st_orphan || ld_orphan;
    end
  end

  assign fault_o     = fault_q;
  assign proto_err_o = proto_q;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          lead_st_ready,
  input logic          lead_ld_ready,
  input logic [CW-1:0] lead_cnt,
  input logic [CW-1:0] trail_cnt,
  input logic          out_st_valid,
  input logic          out_ld_valid,
  input logic          fault_o,
  input logic          proto_err_o
);
  AST_TRAIL_NOT_AHEAD: assert property (@(posedge clk) disable iff (rst) trail_cnt <= lead_cnt); // R7
  AST_LEAD_BOUND: assert property (@(posedge clk) disable iff (rst) lead_cnt <= CW'(DEPTH)); // R6
  AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (rst) !lead_st_ready |-> lead_cnt == CW'(DEPTH)); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst) fault_o |=> fault_o); // R4
  AST_FAULT_HALTS: assert property (@(posedge clk) disable iff (rst) fault_o |=> !out_st_valid && !out_ld_valid); // R5
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (rst) proto_err_o |=> proto_err_o); // R7
  AST_RELEASE_NEEDS_PAIR: assert property (@(posedge clk) disable iff (rst) out_st_valid |-> $past(trail_cnt) != '0); // R2
  AST_LOAD_FREES_SLOT: assert property (@(posedge clk) disable iff (rst) out_ld_valid |-> lead_ld_ready); // R8
endmodule

bind redundant_store_checker rsc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst),
  .lead_st_ready(lead_st_ready), .lead_ld_ready(lead_ld_ready),
  .lead_cnt(lead_cnt), .trail_cnt(trail_cnt),
  .out_st_valid(out_st_valid), .out_ld_valid(out_ld_valid),
  .fault_o(fault_o), .proto_err_o(proto_err_o)
);

// File: tb/redundant_store_checker_test.sv
`timescale 1ns/1ps
module redundant_store_checker_test;
  localparam int AW = 32, DW = 32, DEPTH = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic lead_st_valid = 0, trail_st_valid = 0, lead_ld_valid = 0, trail_ld_valid = 0;
  logic [AW-1:0] lead_st_addr = 0, trail_st_addr = 0, lead_ld_addr = 0, trail_ld_addr = 0;
  logic [DW-1:0] lead_st_data = 0, trail_st_data = 0;
  logic lead_st_ready, lead_ld_ready, out_st_valid, out_ld_valid, fault_o, proto_err_o;
  logic [AW-1:0] out_st_addr, out_ld_addr;
  logic [DW-1:0] out_st_data;

  always #4 clk = ~clk;

  redundant_store_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int st_n = 0, ld_n = 0;
  logic [AW-1:0] st_a [128];
  logic [DW-1:0] st_d [128];
  int st_c [128];
  logic [AW-1:0] ld_a [16];
  int ld_c [16];

  // capture releases away from the clock edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (out_st_valid && st_n < 128) begin
      st_a[st_n] = out_st_addr; st_d[st_n] = out_st_data; st_c[st_n] = cyc; st_n++;
    end
    if (out_ld_valid && ld_n < 16) begin
      ld_a[ld_n] = out_ld_addr; ld_c[ld_n] = cyc; ld_n++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    lead_st_valid = 0; trail_st_valid = 0; lead_ld_valid = 0; trail_ld_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle(3); rst = 0;
    st_n = 0; ld_n = 0;
  endtask

  task automatic put_lst(input logic [31:0] a, input logic [31:0] d);
    lead_st_valid = 1; lead_st_addr = a; lead_st_data = d;
  endtask
  task automatic put_tst(input logic [31:0] a, input logic [31:0] d);
    trail_st_valid = 1; trail_st_addr = a; trail_st_data = d;
  endtask
  task automatic put_lld(input logic [31:0] a);
    lead_ld_valid = 1; lead_ld_addr = a;
  endtask
  task automatic put_tld(input logic [31:0] a);
    trail_ld_valid = 1; trail_ld_addr = a;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "out_st_valid", out_st_valid, 0);
    check("R1", "out_ld_valid", out_ld_valid, 0);
    check("R1", "fault_o", fault_o, 0);
    check("R1", "proto_err_o", proto_err_o, 0);
    check("R1", "lead_st_ready", lead_st_ready, 1);
    check("R1", "lead_ld_ready", lead_ld_ready, 1);
  endtask

  task automatic t_latency_order();
    int tcyc;
    do_reset();
    put_lst(32'h100, 32'hA1); tick();
    idle(2);
    check("R2", "no release before trailing copy", st_n, 0);
    put_tst(32'h100, 32'hA1); tcyc = cyc + 1; tick();
    idle(3);
    check("R2", "one release", st_n, 1);
    check("R2", "release cycle", st_c[0], tcyc + 1);
    check("R2", "release addr", st_a[0], 32'h100);
    // interleaved, with same-cycle leading and trailing commits
    st_n = 0;
    put_lst(32'h200, 32'hB0); tick();
    put_lst(32'h204, 32'hB1); put_tst(32'h200, 32'hB0); tick();
    put_lst(32'h208, 32'hB2); put_tst(32'h204, 32'hB1); tick();
    put_tst(32'h208, 32'hB2); tick();
    idle(4);
    check("R3", "release count", st_n, 3);
    for (int i = 0; i < 3; i++) begin
      check("R3", "order addr", st_a[i], 32'h200 + 4 * i);
      check("R3", "order data", st_d[i], 32'hB0 + i);
    end
    check("R3", "one per cycle", st_c[2] - st_c[0], 2);
    check("R3", "no fault", fault_o, 0);
    check("R7", "no protocol error", proto_err_o, 0);
  endtask

  task automatic t_mismatch(input bit addr_side);
    do_reset();
    put_lst(32'h300, 32'hC0); tick();
    if (addr_side) put_tst(32'h304, 32'hC0); else put_tst(32'h300, 32'hC1);
    tick(); idle(3);
    check("R4", addr_side ? "fault on addr diff" : "fault on data diff", fault_o, 1);
    check("R4", "no release of differing pair", st_n, 0);
    put_lst(32'h400, 32'hD0); tick();
    put_tst(32'h400, 32'hD0); tick();
    put_lld(32'h900); tick();
    put_tld(32'h900); tick();
    idle(3);
    check("R5", "no store release after fault", st_n, 0);
    check("R5", "no load release after fault", ld_n, 0);
    check("R5", "lead queue still accepts", lead_st_ready, 1);
    check("R4", "fault sticky", fault_o, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin put_lst(32'h1000 + 4 * i, 32'h5000 + i); tick(); end
    check("R6", "ready low when full", lead_st_ready, 0);
    put_lst(32'hDEAD, 32'hBEEF); tick();
    for (int i = 0; i < DEPTH; i++) begin put_tst(32'h1000 + 4 * i, 32'h5000 + i); tick(); end
    idle(4);
    check("R6", "releases after fill", st_n, DEPTH);
    check("R6", "last data", st_d[DEPTH-1], 32'h5000 + DEPTH - 1);
    check("R6", "ready back", lead_st_ready, 1);
    check("R6", "no fault", fault_o, 0);
    check("R7", "no protocol error", proto_err_o, 0);
  endtask

  task automatic t_proto();
    do_reset();
    put_tst(32'h500, 32'hE0); tick(); idle(2);
    check("R7", "orphan trailing store flagged", proto_err_o, 1);
    check("R7", "orphan not released", st_n, 0);
    put_lst(32'h600, 32'hE1); tick();
    put_tst(32'h600, 32'hE1); tick(); idle(3);
    check("R7", "later pair released", st_n, 1);
    check("R7", "later pair data", st_d[0], 32'hE1);
    do_reset();
    put_lst(32'h700, 32'hF0); put_tst(32'h700, 32'hF0); tick(); idle(2);
    check("R7", "same-cycle trail on empty flagged", proto_err_o, 1);
    check("R7", "dropped trail not paired", st_n, 0);
    put_tst(32'h700, 32'hF0); tick(); idle(3);
    check("R7", "lead paired with next trail", st_n, 1);
  endtask

  task automatic t_load();
    int tcyc;
    do_reset();
    put_lld(32'h8000); tick();
    check("R8", "slot held", lead_ld_ready, 0);
    put_tld(32'h8000); tcyc = cyc + 1; tick(); idle(2);
    check("R8", "load released", ld_n, 1);
    check("R8", "load addr", ld_a[0], 32'h8000);
    check("R8", "load release cycle", ld_c[0], tcyc);
    check("R8", "slot freed", lead_ld_ready, 1);
    do_reset();
    put_lld(32'h8100); tick();
    put_tld(32'h8104); tick(); idle(2);
    check("R9", "load mismatch fault", fault_o, 1);
    check("R9", "no load release", ld_n, 0);
    check("R9", "slot kept", lead_ld_ready, 0);
    do_reset();
    put_tld(32'h8200); tick(); idle(2);
    check("R10", "orphan load flagged", proto_err_o, 1);
    check("R10", "orphan load not released", ld_n, 0);
  endtask

  // v: 0 both agree, 1 store data differs, 2 load address differs
  task automatic t_same_cycle(input int v);
    do_reset();
    put_lst(32'hA00, 32'h11); put_lld(32'hB00); tick();
    put_tst(32'hA00, (v == 1) ? 32'h12 : 32'h11); tick();
    put_tld((v == 2) ? 32'hB04 : 32'hB00); tick();
    idle(3);
    if (v == 0) begin
      check("R11", "both released", st_n + ld_n, 2);
      check("R11", "same release cycle", st_c[0], ld_c[0]);
      check("R11", "no fault", fault_o, 0);
    end else begin
      check("R11", "store blocked", st_n, 0);
      check("R11", "load blocked", ld_n, 0);
      check("R11", "fault raised", fault_o, 1);
    end
  endtask

  bit done = 0;
  initial begin
    t_reset();
    t_latency_order();
    t_mismatch(1);
    t_mismatch(0);
    t_full();
    t_proto();
    t_load();
    t_same_cycle(0);
    t_same_cycle(1);
    t_same_cycle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule